// File: doc/BRIEF.md
# Banked Check-to-Variable Message Store

This block holds the check-to-variable (C2V) messages of a layered quasi-cyclic LDPC decoder whose check-node processing is split across several processor sets working side by side. Each processor set owns a fixed slice of the banks, one bank per block column it handles. Each bank keeps one word per group, where a group is the set of block rows that all processor sets handle together in one layer cycle. A word packs the `Z` messages of one sub-block.

Each processing step does two things in the same clock edge. A registered write stage captures the freshly updated C2V words for the group now being processed and commits them to that group's slot one cycle later. A registered read stage fetches every bank's word for the following group, so the processors have their inputs ready for the next layer. The group counter steps through the groups in order and wraps around. The read group and the write group are never the same slot, so the two ports of a bank never collide. Starting a new codeword clears every stored message to zero and returns the counter to group 0.

Top module: `c2v_store`

## Requirements
- R1: After reset, `cur_group` is 0 and `rd_data` is all zeros.
- R2: Each cycle with `step` high and `start` low moves `cur_group` to the next group. The order is 0, 1, 2, 3 and then back to 0, with the default of four groups.
- R3: On a `step` cycle, from the following clock edge, `rd_data` holds for every bank the word stored for group `cur_group + 1` (modulo the group count). The value is the one stored before that step.
- R4: The `wr_data` presented on a `step` cycle is stored as the word for group `cur_group` of that cycle. A later read of that group returns it.
- R5: The write commit of one step and the read of a step in the very next cycle target different groups. Both the stored data and the data read stay correct when steps come back to back.
- R6: In a cycle with `step` and `start` both low, `wr_data` is not stored, and `cur_group` and `rd_data` keep their values.
- R7: `start` clears every stored word and `rd_data` to zero and sets `cur_group` to 0. It takes priority over a `step` in the same cycle, and a write still pending from the step before it is discarded.
- R8: Bank b occupies bits `[b*WORD_W +: WORD_W]` of both `wr_data` and `rd_data`, with `WORD_W = Z*MSG_W`. Processor set p owns banks `p*NUM_BANKS/NUM_PROC` upward. Each bank stores and returns its own word, independent of the other banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | New codeword: clear all messages, return to group 0 |
| step | input | 1 | Process one layer: write current group, read next group |
| wr_data | input | NUM_BANKS*Z*MSG_W | Updated C2V words for the current group, one word per bank |
| rd_data | output | NUM_BANKS*Z*MSG_W | Registered C2V words of the next group, one word per bank |
| cur_group | output | clog2(NUM_GROUPS) | Group being processed |

## Verification
The main function is driven by a vector table with four patterns. Back-to-back steps over a full lap show whether the pipelined write reaches its slot before that group is read again. Steps interleaved with idle cycles show whether data offered while idle is wrongly stored. Every bank gets a distinct word built from the bank index and a per-row seed, so a mixed-up bank slice or group address gives a wrong byte instead of a lucky match. A start in mid-stream, including one that coincides with a step, shows whether the clear beats both the step and the write still in flight.

// File: rtl/c2v_pkg.sv
package c2v_pkg;
   localparam int unsigned DEF_BANKS  = 32;
   localparam int unsigned DEF_PROC   = 4;
   localparam int unsigned DEF_GROUPS = 4;
   localparam int unsigned DEF_Z      = 21;
   localparam int unsigned DEF_MSG_W  = 8;

   function automatic int unsigned wrap_inc(input int unsigned g, input int unsigned n);
      return (g + 1 >= n) ? 0 : g + 1;
   endfunction
endpackage

// File: rtl/c2v_grp_ctr.sv
module c2v_grp_ctr #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GW         = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [GW-1:0] cur,
   output logic [GW-1:0] nxt
);
   import c2v_pkg::*;

   always_comb nxt = GW'(wrap_inc(int'(cur), NUM_GROUPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur <= '0;
      else if (clr) cur <= '0;
      else if (adv) cur <= nxt;
   end
endmodule

// File: rtl/c2v_bank.sv
module c2v_bank #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned WORD_W  = 168,
   parameter int unsigned GW      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [GW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [GW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ENTRIES); i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < int'(ENTRIES); i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata <= '0;
      else if (clr) rdata <= '0;
      else if (re)  rdata <= mem[raddr];
   end
endmodule

// File: rtl/c2v_store.sv
module c2v_store #(
   parameter int unsigned NUM_BANKS  = c2v_pkg::DEF_BANKS,
   parameter int unsigned NUM_PROC   = c2v_pkg::DEF_PROC,
   parameter int unsigned NUM_GROUPS = c2v_pkg::DEF_GROUPS,
   parameter int unsigned Z          = c2v_pkg::DEF_Z,
   parameter int unsigned MSG_W      = c2v_pkg::DEF_MSG_W,
   localparam int unsigned WORD_W    = Z * MSG_W,
   localparam int unsigned BUS_W     = NUM_BANKS * WORD_W,
   localparam int unsigned GW        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic [GW-1:0]    cur_group
);
   localparam int unsigned BANKS_PER_PROC = NUM_BANKS / NUM_PROC;
   localparam int unsigned PROC_W         = BANKS_PER_PROC * WORD_W;

   if (NUM_PROC == 0 || NUM_BANKS % NUM_PROC != 0) begin : g_bad_split
      $error("NUM_BANKS must be a multiple of NUM_PROC");
   end
   if (NUM_GROUPS < 3) begin : g_bad_groups
      $error("NUM_GROUPS below 3 lets read and write slots meet");
   end
   if (Z == 0 || MSG_W == 0) begin : g_bad_word
      $error("Z and MSG_W must be nonzero");
   end

   logic          adv;
   logic [GW-1:0] rd_grp;
   logic          wr_pend;
   logic [GW-1:0] wr_grp_q;

   assign adv = step & ~start;

   c2v_grp_ctr #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv),
      .cur(cur_group), .nxt(rd_grp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend  <= 1'b0;
         wr_grp_q <= '0;
      end else begin
         wr_pend <= adv;
         if (adv) wr_grp_q <= cur_group;
      end
   end

   for (genvar p = 0; p < int'(NUM_PROC); p++) begin : g_proc
      logic [PROC_W-1:0] wr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   wr_q <= '0;
         else if (adv) wr_q <= wr_data[p*PROC_W +: PROC_W];
      end

      for (genvar b = 0; b < int'(BANKS_PER_PROC); b++) begin : g_bank
         c2v_bank #(.ENTRIES(NUM_GROUPS), .WORD_W(WORD_W), .GW(GW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .we    (wr_pend),
            .waddr (wr_grp_q),
            .wdata (wr_q[b*WORD_W +: WORD_W]),
            .re    (adv),
            .raddr (rd_grp),
            .rdata (rd_data[(p*BANKS_PER_PROC + b)*WORD_W +: WORD_W])
         );
      end
   end
endmodule

// File: rtl/c2v_store_chk.sv
module c2v_store_chk #(
   parameter int unsigned NUM_GROUPS = 4,
   parameter int unsigned GW         = 2,
   parameter int unsigned BUS_W      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             step,
   input logic [GW-1:0]    cur_group,
   input logic [BUS_W-1:0] rd_data,
   input logic             wr_pend,
   input logic [GW-1:0]    wr_grp,
   input logic [GW-1:0]    rd_grp
);
   localparam logic [GW-1:0] LAST = GW'(NUM_GROUPS - 1);

   AST_RW_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && step && !start) |-> (wr_grp != rd_grp)); // R5

   AST_GROUP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start) |=> (cur_group == (($past(cur_group) == LAST) ? '0 : $past(cur_group) + 1'b1))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !start) |=> ($stable(cur_group) && $stable(rd_data))); // R6

   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cur_group == '0 && rd_data == '0 && !wr_pend)); // R7

   AST_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start) |=> (wr_pend && wr_grp == $past(cur_group))); // R4
endmodule

bind c2v_store c2v_store_chk #(.NUM_GROUPS(NUM_GROUPS), .GW(GW), .BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .step(step), .cur_group(cur_group),
   .rd_data(rd_data), .wr_pend(wr_pend), .wr_grp(wr_grp_q), .rd_grp(rd_grp)
);

// File: tb/tb_c2v_store.sv
module tb_c2v_store;
   localparam int NB = 32, NP = 4, NG = 4, Z = 21, MW = 8;
   localparam int WORD_W = Z * MW;
   localparam int BUS_W  = NB * WORD_W;
   localparam int NROWS  = 16;

   // row = {start, step, seed}
   localparam logic [9:0] VEC [NROWS] = '{
      {1'b0, 1'b1, 8'h11}, {1'b0, 1'b1, 8'h22}, {1'b0, 1'b1, 8'h33}, {1'b0, 1'b1, 8'h44},
      {1'b0, 1'b0, 8'h99}, {1'b0, 1'b1, 8'h55}, {1'b0, 1'b1, 8'h66}, {1'b0, 1'b0, 8'h77},
      {1'b0, 1'b1, 8'h88}, {1'b0, 1'b1, 8'h0A}, {1'b1, 1'b1, 8'h0B}, {1'b0, 1'b1, 8'h0C},
      {1'b0, 1'b1, 8'h0D}, {1'b1, 1'b0, 8'h0E}, {1'b0, 1'b1, 8'h0F}, {1'b0, 1'b1, 8'h10}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             step = 1'b0;
   logic [BUS_W-1:0] wr_data = '0;
   logic [BUS_W-1:0] rd_data;
   logic [1:0]       cur_group;

   int checks = 0, errors = 0;
   logic [BUS_W-1:0] exp_mem [NG];
   logic [BUS_W-1:0] exp_rd;
   int               exp_cur;

   always #10 clk = ~clk;

   c2v_store dut (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .wr_data(wr_data), .rd_data(rd_data), .cur_group(cur_group)
   );

   function automatic logic [BUS_W-1:0] mk_bus(input int seed);
      logic [BUS_W-1:0] v;
      for (int b = 0; b < NB; b++)
         for (int j = 0; j < Z; j++)
            v[b*WORD_W + j*MW +: MW] = 8'(seed * 5 + b * 11 + j);
      return v;
   endfunction

   task automatic model(input logic st, input logic sp, input logic [BUS_W-1:0] w);
      if (st) begin
         for (int g = 0; g < NG; g++) exp_mem[g] = '0;
         exp_rd = '0; exp_cur = 0;
      end else if (sp) begin
         int nx;
         nx = (exp_cur + 1) % NG;
         exp_rd = exp_mem[nx];
         exp_mem[exp_cur] = w;
         exp_cur = nx;
      end
   endtask

   task automatic check_out(input string tag, input int row);
      checks++;
      if (int'(cur_group) != exp_cur) begin
         errors++;
         $display("FAIL R2 %s row %0d cur_group got %0d exp %0d", tag, row, cur_group, exp_cur);
      end
      for (int b = 0; b < NB; b++) begin
         checks++;
         if (rd_data[b*WORD_W +: WORD_W] !== exp_rd[b*WORD_W +: WORD_W]) begin
            errors++;
            $display("FAIL R3 R8 %s row %0d bank %0d got %h exp %h", tag, row, b,
                     rd_data[b*WORD_W +: WORD_W], exp_rd[b*WORD_W +: WORD_W]);
         end
      end
   endtask

   task automatic cycle(input logic st, input logic sp, input logic [BUS_W-1:0] w);
      start = st; step = sp; wr_data = w;
      @(posedge clk);
      model(st, sp, w);
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int g = 0; g < NG; g++) exp_mem[g] = '0;
      exp_rd = '0; exp_cur = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 reset", -1);

      // table walk: R4 R5 R6 R7 exercised by rows
      for (int r = 0; r < NROWS; r++) begin
         cycle(VEC[r][9], VEC[r][8], mk_bus(int'(VEC[r][7:0])));
         check_out("table", r);
      end

      // R6: idle cycles with changing data are ignored
      for (int k = 0; k < 3; k++) begin
         cycle(1'b0, 1'b0, mk_bus(200 + k));
         check_out("R6 idle", k);
      end
      // R4 R5: back-to-back lap reveals what was stored
      for (int k = 0; k < 2 * NG; k++) begin
         cycle(1'b0, 1'b1, mk_bus(100 + k));
         check_out("R5 lap", k);
      end
      // R7: start right after a step drops the pending write
      cycle(1'b0, 1'b1, mk_bus(77));
      cycle(1'b1, 1'b0, mk_bus(78));
      check_out("R7 start", 0);
      for (int k = 0; k < NG; k++) begin
         cycle(1'b0, 1'b1, '0);
         check_out("R7 cleared", k);
      end

      start = 1'b0; step = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule